// File: doc/BRIEF.md
# Two-Clock Replay FIFO with Ninth-Bit Parity

This block is a first-in first-out store for 9-bit words whose write and read sides run on separate, possibly unrelated clocks. The two clocks may also be tied together. A producer presents a word and holds a write enable, and one word is stored on every write-clock rising edge. A consumer holds a read enable, and one word is moved into a registered output on every read-clock rising edge. Both sides may be active at the same time. The number of words held is a parameter: 512 by default, with 2048 and 4096 also supported.

Status is split by clock domain. The read side produces empty and almost empty. The write side produces full, half full and almost full. Each pointer crosses to the other domain as Gray code through two flops. A small program register holds three things: the almost threshold, the parity controls and the parity polarity. It can be written only while the master reset is held. Parity can be off, generated into bit 8 as words are written, or checked on bit 8 as words are read.

A replay command rewinds the read side to the first word stored since the last master reset. The stored words are then delivered again under the read enable.

Top module: `fifo_rt`

## Requirements
- R1: While `rst_n` is low, `empty` is 1 and `full`, `half`, `afull` and `aempty` are 0. Both pointers are cleared.
- R2: On every `wclk` rising edge with `wr_en` high and `full` low, one `wr_data` word is stored. The words are delivered on the read side in the order they were written, with neither clock waiting for the other.
- R3: On a `rclk` rising edge with `rd_en` high and `empty` low, the oldest word appears on `rd_data` after that edge. `rd_data` holds that word until the next accepted read.
- R4: `full` is 1 when DEPTH words are held. A write while `full` is 1 stores nothing and does not disturb the order or content of the held words.
- R5: A read while `empty` is 1 has no effect: `rd_data` keeps its value and no word is consumed.
- R6: `half` (write side) is 1 when the held count is at least DEPTH/2, and 0 below that.
- R7: `afull` (write side) is 1 when the count is at least DEPTH minus the offset. `aempty` (read side) is 1 when the count is at most the offset.
- R8: The program register is sampled on every `wclk` rising edge while `rst_n` is low. With `cfg_load` high it takes `cfg_ofs`, `cfg_par_en`, `cfg_par_chk` and `cfg_par_odd`. With `cfg_load` low it returns to its defaults: offset 8 and parity off. The last such edge before reset is released decides the value.
- R9: A `rclk` edge with `rt_n` low while `rd_en` and `wr_en` are both low rewinds the read side to the first word written since reset. Stored data and the write side are unchanged, and `empty` and `aempty` are recomputed. The held words are then read again in order. This is valid while no more than DEPTH words have been written since reset.
- R10: With `cfg_par_en`=1 and `cfg_par_chk`=0, bit 8 of each stored word is replaced by a parity bit over bits 7..0. For even polarity (`cfg_par_odd`=0) the bit is the XOR of bits 7..0. For odd polarity it is the inverse.
- R11: With `cfg_par_en`=1 and `cfg_par_chk`=1, bits 7..0 are delivered unchanged and `rd_data[8]` is 1 exactly when the stored 9 bits fail the parity. With even polarity the XOR of all 9 bits must be 0; with odd polarity it must be 1.
- R12: With `cfg_par_en`=0, all 9 bits pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low master reset, both domains |
| wr_en | input | 1 | Write enable, active high |
| wr_data | input | 9 | Word to store |
| rd_en | input | 1 | Read enable, active high |
| rd_data | output | 9 | Registered output word |
| rt_n | input | 1 | Active-low replay command, sampled on rclk |
| cfg_load | input | 1 | Program register load strobe, used during reset |
| cfg_ofs | input | AW | Almost threshold offset in words |
| cfg_par_en | input | 1 | Parity function enable |
| cfg_par_chk | input | 1 | 1 = check on read, 0 = generate on write |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| empty | output | 1 | No word held (read side) |
| aempty | output | 1 | Count at most the offset (read side) |
| half | output | 1 | Count at least DEPTH/2 (write side) |
| afull | output | 1 | Count at least DEPTH minus offset (write side) |
| full | output | 1 | DEPTH words held (write side) |

## Verification
Each kind of pointer or count fault shows up at the ports within a few read-clock cycles:
- A pointer that skips or stalls appears as a word out of order or repeated in the scoreboard stream, at the first read after the fault.
- A wrong synchronised count shows up as a flag at the wrong count. The flags are sampled at exact word counts on either side of each threshold, once the synchronisers have settled.
- A replay that rewinds to the wrong place produces a mismatch on the first replayed word.
- A parity mode that is decoded wrongly corrupts bit 8 of every word in that phase.

// File: rtl/fifo_rt.sv
module fifo_rt #(
  parameter int DEPTH   = 512,
  parameter int OFS_DEF = 8,
  parameter int AW      = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [8:0]    wr_data,
  input  logic          rd_en,
  output logic [8:0]    rd_data,
  input  logic          rt_n,
  input  logic          cfg_load,
  input  logic [AW-1:0] cfg_ofs,
  input  logic          cfg_par_en,
  input  logic          cfg_par_chk,
  input  logic          cfg_par_odd,
  output logic          empty,
  output logic          aempty,
  output logic          half,
  output logic          afull,
  output logic          full
);

  localparam logic [AW:0] CNT_FULL = (AW+1)'(DEPTH);
  localparam logic [AW:0] CNT_HALF = (AW+1)'(DEPTH / 2);

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [AW:0] b2g(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [AW-1:0] ofs;
  logic          p_en, p_chk, p_odd;

  always_ff @(posedge wclk)
    if (!rst_n) begin
      if (cfg_load) begin
        ofs <= cfg_ofs; p_en <= cfg_par_en; p_chk <= cfg_par_chk; p_odd <= cfg_par_odd;
      end else begin
        ofs <= AW'(OFS_DEF); p_en <= 1'b0; p_chk <= 1'b0; p_odd <= 1'b0;
      end
    end

  logic [8:0] mem [DEPTH];

  logic [AW:0] wbin, wgray, rq1, rq2;
  logic [AW:0] rbin, rgray, wq1, wq2;

  logic        wr_ok;
  logic [AW:0] wbin_nx, rq2b, wcnt_nx;
  logic        gen_par;
  logic [8:0]  wword;

  assign wr_ok   = wr_en && !full;
  assign wbin_nx = wbin + (AW+1)'(wr_ok);
  assign rq2b    = g2b(rq2);
  assign wcnt_nx = wbin_nx - rq2b;
  assign gen_par = p_odd ? ~^wr_data[7:0] : ^wr_data[7:0];
  assign wword   = (p_en && !p_chk) ? {gen_par, wr_data[7:0]} : wr_data;

  always_ff @(posedge wclk)
    if (wr_ok) mem[wbin[AW-1:0]] <= wword;

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      wbin <= '0; wgray <= '0; rq1 <= '0; rq2 <= '0;
      full <= 1'b0; half <= 1'b0; afull <= 1'b0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= b2g(wbin_nx);
      rq1   <= rgray;
      rq2   <= rq1;
      full  <= wcnt_nx == CNT_FULL;
      half  <= wcnt_nx >= CNT_HALF;
      afull <= wcnt_nx >= CNT_FULL - {1'b0, ofs};
    end

  logic        rd_ok, rt_go;
  logic [AW:0] rbin_nx, wq2b, rcnt_nx;
  logic [8:0]  rword;
  logic        chk_err;

  assign rd_ok   = rd_en && !empty;
  assign rt_go   = !rt_n && !rd_en && !wr_en;
  assign rbin_nx = rt_go ? '0 : rbin + (AW+1)'(rd_ok);
  assign wq2b    = g2b(wq2);
  assign rcnt_nx = wq2b - rbin_nx;
  assign rword   = mem[rbin[AW-1:0]];
  assign chk_err = p_odd ? ~^rword : ^rword;

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      rbin <= '0; rgray <= '0; wq1 <= '0; wq2 <= '0;
      empty <= 1'b1; aempty <= 1'b0; rd_data <= '0;
    end else begin
      rbin   <= rbin_nx;
      rgray  <= b2g(rbin_nx);
      wq1    <= wgray;
      wq2    <= wq1;
      empty  <= rcnt_nx == '0;
      aempty <= rcnt_nx <= {1'b0, ofs};
      if (rd_ok)
        rd_data <= (p_en && p_chk) ? {chk_err, rword[7:0]} : rword;
    end

  a_r4_count_bound: assert property (@(posedge wclk) disable iff (!rst_n)
    (wbin - rq2b) <= CNT_FULL);
  a_r4_no_overflow: assert property (@(posedge wclk) disable iff (!rst_n)
    (full && wr_en) |=> $stable(wbin));
  a_r6_flag_order: assert property (@(posedge wclk) disable iff (!rst_n)
    full |-> (half && afull));
  a_r2_gray_step: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
  a_r5_no_underflow: assert property (@(posedge rclk) disable iff (!rst_n)
    (empty && rd_en) |=> $stable(rd_data));
  a_r9_rewind: assert property (@(posedge rclk) disable iff (!rst_n)
    (!rt_n && !rd_en && !wr_en) |=> (rgray == '0));

endmodule

// File: tb/fifo_rt_bench.sv
module fifo_rt_bench;
  localparam int DEPTH = 512;
  localparam int AW = $clog2(DEPTH);

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, rt_n = 1, cfg_load = 0;
  logic [8:0] wr_data = '0;
  logic [8:0] rd_data;
  logic [AW-1:0] cfg_ofs = '0;
  logic cfg_par_en = 0, cfg_par_chk = 0, cfg_par_odd = 0;
  logic empty, aempty, half, afull, full;

  always #2.5 wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  fifo_rt #(.DEPTH(DEPTH)) u_fifo_rt (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .rt_n(rt_n), .cfg_load(cfg_load), .cfg_ofs(cfg_ofs),
    .cfg_par_en(cfg_par_en), .cfg_par_chk(cfg_par_chk), .cfg_par_odd(cfg_par_odd),
    .empty(empty), .aempty(aempty), .half(half), .afull(afull), .full(full));

  int checks = 0, errors = 0;
  int wcount = 0;
  logic [8:0] exp_q[$];
  logic [8:0] hist[$];
  string cur_tag = "R2";
  logic rd_go = 0, rd_force = 0, pend = 0;
  logic [1:0] pmode = 0;

  task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] expect_of(logic [8:0] d);
    case (pmode)
      2'd1: return {^d[7:0], d[7:0]};
      2'd2: return {~^d[7:0], d[7:0]};
      2'd3: return {~^d, d[7:0]};
      default: return d;
    endcase
  endfunction

  always @(negedge rclk) begin
    if (pend) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL %s actual=%h expected=none", cur_tag, rd_data);
      end else begin
        check(cur_tag, rd_data, exp_q.pop_front());
      end
    end
    rd_en = (rd_go && !empty) || rd_force;
    pend = rd_en && !empty && rst_n;
  end

  task automatic put_n(int n);
    for (int i = 0; i < n; i++) begin
      logic [8:0] d;
      d = 9'(wcount * 37 + 5);
      wcount++;
      @(negedge wclk);
      wr_en = 1; wr_data = d;
      exp_q.push_back(expect_of(d));
      hist.push_back(expect_of(d));
    end
    @(negedge wclk);
    wr_en = 0;
    repeat (8) @(negedge rclk);
  endtask

  task automatic drain();
    rd_go = 1;
    wait (exp_q.size() == 0);
    repeat (4) @(negedge rclk);
    rd_go = 0;
    repeat (4) @(negedge rclk);
  endtask

  task automatic do_reset(logic load, logic [AW-1:0] ofs, logic pe, logic pc, logic po);
    rd_go = 0; rd_force = 0; wr_en = 0; rt_n = 1;
    repeat (3) @(negedge rclk);
    @(negedge wclk);
    rst_n = 0;
    cfg_load = load; cfg_ofs = ofs; cfg_par_en = pe; cfg_par_chk = pc; cfg_par_odd = po;
    repeat (4) @(negedge wclk);
    rst_n = 1;
    @(negedge wclk);
    cfg_load = 0;
    exp_q.delete(); hist.delete();
    repeat (4) @(negedge rclk);
  endtask

  initial begin
    #200us;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [8:0] held;
    // R1 reset state
    repeat (3) @(negedge wclk);
    check("R1 empty", {8'd0, empty}, 9'd1);
    check("R1 full", {8'd0, full}, 9'd0);
    check("R1 half", {8'd0, half}, 9'd0);
    check("R1 afull", {8'd0, afull}, 9'd0);
    check("R1 aempty", {8'd0, aempty}, 9'd0);

    // default program register: offset 8, parity off (R8, R12)
    pmode = 0;
    do_reset(0, '0, 0, 0, 0);
    put_n(8);
    check("R7 aempty at offset", {8'd0, aempty}, 9'd1);
    check("R2 empty after writes", {8'd0, empty}, 9'd0);
    put_n(1);
    check("R7 aempty above offset", {8'd0, aempty}, 9'd0);
    put_n(11);
    cur_tag = "R12 passthrough";
    drain();
    check("R3 empty after drain", {8'd0, empty}, 9'd1);
    check("R7 aempty drained", {8'd0, aempty}, 9'd1);

    // R5 read while empty
    held = rd_data;
    rd_force = 1;
    repeat (5) @(negedge rclk);
    rd_force = 0;
    repeat (2) @(negedge rclk);
    check("R5 rd_data held", rd_data, held);
    check("R5 still empty", {8'd0, empty}, 9'd1);

    // R9 replay of all 20 words
    @(negedge rclk); rt_n = 0;
    @(negedge rclk); rt_n = 1;
    repeat (2) @(negedge rclk);
    check("R9 empty recomputed", {8'd0, empty}, 9'd0);
    check("R9 aempty recomputed", {8'd0, aempty}, 9'd0);
    foreach (hist[i]) exp_q.push_back(hist[i]);
    cur_tag = "R9 replay";
    drain();

    // R6 R7 R4 thresholds on the write side
    put_n(255);
    @(negedge wclk);
    check("R6 half below", {8'd0, half}, 9'd0);
    put_n(1);
    @(negedge wclk);
    check("R6 half at", {8'd0, half}, 9'd1);
    check("R7 afull low", {8'd0, afull}, 9'd0);
    put_n(247);
    @(negedge wclk);
    check("R7 afull below", {8'd0, afull}, 9'd0);
    put_n(1);
    @(negedge wclk);
    check("R7 afull at", {8'd0, afull}, 9'd1);
    check("R4 not full", {8'd0, full}, 9'd0);
    put_n(7);
    @(negedge wclk);
    check("R4 full below", {8'd0, full}, 9'd0);
    put_n(1);
    @(negedge wclk);
    check("R4 full at depth", {8'd0, full}, 9'd1);
    @(negedge wclk);
    wr_en = 1; wr_data = 9'h1AA;
    repeat (3) @(negedge wclk);
    wr_en = 0;
    repeat (2) @(negedge wclk);
    check("R4 full after overflow", {8'd0, full}, 9'd1);
    cur_tag = "R4 order after overflow";
    drain();
    check("R2 empty after full drain", {8'd0, empty}, 9'd1);

    // R8 loaded offset 16, R10 even generation
    pmode = 1;
    do_reset(1, AW'(16), 1, 0, 0);
    put_n(16);
    check("R8 aempty at loaded offset", {8'd0, aempty}, 9'd1);
    put_n(1);
    check("R8 aempty above loaded offset", {8'd0, aempty}, 9'd0);
    cur_tag = "R10 even generate";
    drain();

    // R10 odd generation
    pmode = 2;
    do_reset(1, AW'(8), 1, 0, 1);
    put_n(12);
    cur_tag = "R10 odd generate";
    drain();

    // R11 odd check
    pmode = 3;
    do_reset(1, AW'(8), 1, 1, 1);
    put_n(12);
    cur_tag = "R11 odd check";
    drain();

    // R11 even check
    pmode = 0;
    do_reset(1, AW'(8), 1, 1, 0);
    for (int i = 0; i < 12; i++) begin
      logic [8:0] d;
      d = 9'(i * 53 + 3);
      @(negedge wclk);
      wr_en = 1; wr_data = d;
      exp_q.push_back({^d, d[7:0]});
    end
    @(negedge wclk);
    wr_en = 0;
    repeat (8) @(negedge rclk);
    cur_tag = "R11 even check";
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule